// File: doc/BRIEF.md
# Packed Reset Control Fanout

This block turns three writable control words into individual reset lines. The fabric reset word is 32 bits wide. Only seventeen of its bits are meaningful, and they are scattered across the word. The block keeps only those bits and packs them onto seventeen adjacent output lines. The lowest four of those lines are active low, so their values are inverted on the way out.

A second control word drives the reset lines of two processor cores. A third control word, the system word, turns a write with its low bit set into a single-cycle soft-reset request.

Writes come in on a plain write port. Each write carries a register select and a permission flag that has already been resolved upstream. A write made while the permission flag is low is dropped. The stored fabric word can be read back at all times: it is the masked value, with no inversion applied.

Top module: `rst_fanout`

## Requirements
- R1: After reset the stored fabric word reads 0x01F33F0F, the fabric outputs read 17'h1FFF0, both core lines are 0 and the system request is 0.
- R2: An accepted write to the fabric word (select 0) stores the write data ANDed with 0x01F33F0F. Read-back returns that stored value with no inversion.
- R3: The valid fabric bits drive the outputs in ascending order: bits 3..0 drive outputs 3..0, bits 13..8 drive outputs 9..4, bits 17..16 drive outputs 11..10, and bits 24..20 drive outputs 16..12.
- R4: Fabric outputs 3..0 carry the inverse of their stored bits. Outputs 16..4 carry their stored bits unchanged.
- R5: An accepted write to the core word (select 1) sets core line 0 from data bit 0 and core line 1 from data bit 1.
- R6: An accepted write to the system word (select 2) with data bit 0 set raises the system request for exactly one cycle. A write with bit 0 clear raises nothing.
- R7: While the permission input is 0, a write changes no stored word, no core line and no fabric output, and it raises no request.
- R8: Every output reflects an accepted write from the first rising clock edge after that write, and holds its value when no write is made.
- R9: A write with select 3 changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Register select: 0 fabric, 1 core, 2 system, 3 none |
| wr_data | input | 32 | Write data |
| wr_unlocked | input | 1 | Permission flag; when 0 the write is dropped |
| fab_rst | output | 17 | Packed fabric reset lines |
| core_rst | output | 2 | Core reset lines |
| sys_rst_req | output | 1 | Single-cycle soft-reset request |
| fab_rd | output | 32 | Stored, masked fabric word |

## Verification
The assertions check several properties on every cycle:
- Reserved bits never show up in the read-back.
- A dropped write leaves every stored word unchanged.
- The system request, the core lines and the fabric word change only in the cycle after a matching accepted write.

The bit-by-bit packing order, the polarity of each output group and the exact stored values can only be shown by the bench's scenarios. These are walking-one patterns, all-ones and all-zeros writes, locked writes and writes with the unused select, each compared against an independent model.

// File: rtl/rstf_pkg.sv
package rstf_pkg;

  typedef enum logic [1:0] {
    SEL_FAB  = 2'd0,
    SEL_CORE = 2'd1,
    SEL_SYS  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // number of set bits of m strictly below position b
  function automatic int unsigned ones_below(logic [31:0] m, int unsigned b);
    int unsigned n;
    n = 0;
    for (int unsigned k = 0; k < 32; k++) begin
      if (k < b && m[k]) n++;
    end
    return n;
  endfunction

endpackage

// File: rtl/rstf_fab_reg.sv
module rstf_fab_reg
  import rstf_pkg::*;
#(
  parameter int unsigned W       = 32,
  parameter logic [31:0] MASK    = 32'h01F3_3F0F,
  parameter logic [31:0] INV     = 32'h0000_000F,
  parameter logic [31:0] RST_VAL = 32'h01F3_3F0F,
  localparam int unsigned NOUT   = ones_below(MASK, W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [W-1:0]    din,
  output logic [W-1:0]    stored_o,
  output logic [NOUT-1:0] rst_o
);

  logic [W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word_q <= RST_VAL[W-1:0] & MASK[W-1:0];
    else if (load) word_q <= din & MASK[W-1:0];
  end

  assign stored_o = word_q;

  // squeeze reserved bits out: each valid bit lands on the next free line
  for (genvar b = 0; b < W; b++) begin : g_bit
    if (MASK[b]) begin : g_on
      localparam int unsigned IDX = ones_below(MASK, b);
      assign rst_o[IDX] = word_q[b] ^ INV[b];
    end
  end

endmodule

// File: rtl/rstf_core_reg.sv
module rstf_core_reg #(
  parameter int unsigned NCORE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NCORE-1:0] din,
  output logic [NCORE-1:0] rst_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rst_o <= '0;
    else if (load) rst_o <= din;
  end

endmodule

// File: rtl/rstf_sys_pulse.sv
module rstf_sys_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic req_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_o <= 1'b0;
    else        req_o <= fire;
  end

endmodule

// File: rtl/rst_fanout.sv
module rst_fanout
  import rstf_pkg::*;
#(
  parameter int unsigned FAB_W       = 32,
  parameter logic [31:0] FAB_MASK    = 32'h01F3_3F0F,
  parameter logic [31:0] FAB_INV     = 32'h0000_000F,
  parameter logic [31:0] FAB_RST_VAL = 32'h01F3_3F0F,
  parameter int unsigned NCORE       = 2,
  localparam int unsigned FAB_OUTS   = ones_below(FAB_MASK, FAB_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [1:0]          wr_sel,
  input  logic [FAB_W-1:0]    wr_data,
  input  logic                wr_unlocked,
  output logic [FAB_OUTS-1:0] fab_rst,
  output logic [NCORE-1:0]    core_rst,
  output logic                sys_rst_req,
  output logic [FAB_W-1:0]    fab_rd
);

  reg_sel_e sel;
  logic     accept;
  logic     ld_fab, ld_core, fire_sys;

  assign sel      = reg_sel_e'(wr_sel);
  assign accept   = wr_en & wr_unlocked;
  assign ld_fab   = accept && (sel == SEL_FAB);
  assign ld_core  = accept && (sel == SEL_CORE);
  assign fire_sys = accept && (sel == SEL_SYS) && wr_data[0];

  rstf_fab_reg #(
    .W(FAB_W), .MASK(FAB_MASK), .INV(FAB_INV), .RST_VAL(FAB_RST_VAL)
  ) u_fab (
    .clk(clk), .rst_n(rst_n), .load(ld_fab), .din(wr_data),
    .stored_o(fab_rd), .rst_o(fab_rst)
  );

  rstf_core_reg #(.NCORE(NCORE)) u_core (
    .clk(clk), .rst_n(rst_n), .load(ld_core), .din(wr_data[NCORE-1:0]),
    .rst_o(core_rst)
  );

  rstf_sys_pulse u_sys (
    .clk(clk), .rst_n(rst_n), .fire(fire_sys), .req_o(sys_rst_req)
  );

endmodule

// File: rtl/rst_fanout_chk.sv
module rst_fanout_chk #(
  parameter int unsigned FAB_W    = 32,
  parameter logic [31:0] FAB_MASK = 32'h01F3_3F0F,
  parameter int unsigned FAB_OUTS = 17,
  parameter int unsigned NCORE    = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [1:0]          wr_sel,
  input logic [FAB_W-1:0]    wr_data,
  input logic                wr_unlocked,
  input logic [FAB_OUTS-1:0] fab_rst,
  input logic [NCORE-1:0]    core_rst,
  input logic                sys_rst_req,
  input logic [FAB_W-1:0]    fab_rd
);

  assert_rdback_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fab_rd & ~FAB_MASK[FAB_W-1:0]) == '0);

  assert_locked_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_unlocked) |=> ($stable(fab_rd) && $stable(core_rst)
                                 && $stable(fab_rst) && !sys_rst_req));

  assert_pulse_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> $past(wr_en && wr_unlocked && wr_sel == 2'd2 && wr_data[0]));

  assert_core_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(core_rst) |-> $past(wr_en && wr_unlocked && wr_sel == 2'd1));

  assert_fab_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fab_rst) |-> $past(wr_en && wr_unlocked && wr_sel == 2'd0));

  assert_none_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd3) |=> ($stable(fab_rd) && $stable(core_rst) && !sys_rst_req));

endmodule

bind rst_fanout rst_fanout_chk #(
  .FAB_W(FAB_W), .FAB_MASK(FAB_MASK), .FAB_OUTS(FAB_OUTS), .NCORE(NCORE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .wr_unlocked(wr_unlocked), .fab_rst(fab_rst), .core_rst(core_rst),
  .sys_rst_req(sys_rst_req), .fab_rd(fab_rd)
);

// File: tb/rst_fanout_bench.sv
module rst_fanout_bench;

  typedef struct {
    logic [31:0] rd;
    logic [16:0] fab;
    logic [1:0]  core;
    logic        sys;
    int          due;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic        wr_unlocked = 1'b0;
  logic [16:0] fab_rst;
  logic [1:0]  core_rst;
  logic        sys_rst_req;
  logic [31:0] fab_rd;

  int   n_run = 0, n_fail = 0, cyc = 0;
  bit   done = 0;
  exp_t q[$];

  logic [31:0] m_word = 32'h01F3_3F0F;
  logic [1:0]  m_core = 2'b00;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rst_fanout u_rst_fanout (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .wr_unlocked(wr_unlocked), .fab_rst(fab_rst), .core_rst(core_rst),
    .sys_rst_req(sys_rst_req), .fab_rd(fab_rd)
  );

  function automatic logic [16:0] pack(logic [31:0] w);
    return {w[24:20], w[17:16], w[13:8], ~w[3:0]};
  endfunction

  task automatic push(logic sys, string req);
    exp_t e;
    e.rd = m_word; e.fab = pack(m_word); e.core = m_core;
    e.sys = sys; e.due = cyc + 1; e.req = req;
    q.push_back(e);
  endtask

  // drive one write cycle and record the expected state after the next edge
  task automatic wr(logic [1:0] sel, logic [31:0] d, logic unl, string req);
    logic s;
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d; wr_unlocked = unl;
    s = 1'b0;
    if (unl) begin
      if (sel == 2'd0) m_word = d & 32'h01F3_3F0F;
      if (sel == 2'd1) m_core = d[1:0];
      if (sel == 2'd2) s = d[0];
    end
    push(s, req);
  endtask

  task automatic idle(string req);
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 2'd0; wr_data = '0;
    push(1'b0, req);
  endtask

  // monitor: compare items whose edge has passed
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      n_run++;
      if (fab_rd !== e.rd || fab_rst !== e.fab || core_rst !== e.core
          || sys_rst_req !== e.sys) begin
        n_fail++;
        $display("FAIL %s: got rd=%h fab=%h core=%b sys=%b, want rd=%h fab=%h core=%b sys=%b",
                 e.req, fab_rd, fab_rst, core_rst, sys_rst_req,
                 e.rd, e.fab, e.core, e.sys);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    push(1'b0, "R1 reset state");
    idle("R1 reset hold");
    // R3 and R4: a walking one over every valid bit
    for (int b = 0; b < 25; b++) begin
      wr(2'd0, 32'h1 << b, 1'b1, "R3 R4 walking bit");
    end
    wr(2'd0, 32'hFFFF_FFFF, 1'b1, "R2 all ones masked");
    idle("R8 hold after write");
    wr(2'd0, 32'h0000_0000, 1'b1, "R4 all zero low group asserted");
    wr(2'd0, 32'hA5C3_F0F6, 1'b1, "R2 mixed pattern");
    wr(2'd1, 32'h0000_0001, 1'b1, "R5 core0");
    wr(2'd1, 32'hFFFF_FFFE, 1'b1, "R5 core1");
    wr(2'd1, 32'h0000_0003, 1'b1, "R5 both cores");
    wr(2'd2, 32'h0000_0001, 1'b1, "R6 request pulse");
    idle("R6 pulse ends");
    wr(2'd2, 32'hFFFF_FFFE, 1'b1, "R6 bit0 clear no pulse");
    wr(2'd0, 32'h0000_0000, 1'b0, "R7 locked fabric");
    wr(2'd1, 32'h0000_0000, 1'b0, "R7 locked core");
    wr(2'd2, 32'h0000_0001, 1'b0, "R7 locked system");
    idle("R7 after locked");
    wr(2'd3, 32'hFFFF_FFFF, 1'b1, "R9 unused select");
    idle("R9 after unused select");
    wr(2'd2, 32'h0000_0001, 1'b1, "R6 back-to-back first");
    wr(2'd2, 32'h0000_0001, 1'b1, "R6 back-to-back second");
    idle("R6 back-to-back end");
    idle("R8 final");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: got hang, want completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule